// File: doc/BRIEF.md
# Verified Period Counter with Preload

This block keeps the absolute position of a fine incremental track as a count of its zero crossings. Each crossing event moves a 16-bit up/down counter by one step. A preload strobe seeds the counter with an absolute value. The counter and the value it checks against both use crossing units, so the counter counts two crossings per signal period.

When a conversion completes elsewhere, an independently computed absolute value arrives with a strobe. A two-bit policy input decides whether that value is compared with the counter:
- Policy 0 never compares.
- Policy 1 compares only while the signal frequency is under its limit.
- Policies 2 and 3 always compare.

A mismatch raises a sticky error flag, which stays set until an explicit clear.

A second output gives the count aligned with the fine-track phase. The top two phase bits (the quadrant) are compared with the counter's lowest bit. A crossing that has not yet been counted, or one counted early, is then corrected by one step before the value is registered out.

Top module: `period_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, `count`, `sync_count` and `cnt_err` become zero.
- R2: When `xing_valid` is high and `load_valid` is low, `count` steps by +1 (`xing_up`=1) or -1 (`xing_up`=0) at the edge, modulo 2^16. So 0xFFFF+1 gives 0 and 0-1 gives 0xFFFF. With neither strobe high, `count` holds.
- R3: When `load_valid` is high, `count` takes `load_value` at the edge, even if a crossing event arrives in the same cycle.
- R4: With `vmode`=2'b00, an `abs_valid` strobe never sets `cnt_err`, whatever `abs_value` is.
- R5: With `vmode`=2'b01, a strobe is compared only if `freq_over` is low in the same cycle. A strobe seen while `freq_over` is high is skipped. Strobes that arrive after `freq_over` falls are compared again.
- R6: With `vmode`=2'b10 or 2'b11, every `abs_valid` strobe is compared.
- R7: A compared strobe checks `abs_value` against the `count` held before that edge, ignoring any crossing or preload in the same cycle. A mismatch makes `cnt_err` high from that edge on.
- R8: `cnt_err` stays high until an edge where `err_clr` is high and no mismatch is detected; a mismatch in the same cycle wins over the clear.
- R9: `sync_count` is registered from the pre-edge `count` and the `phase_q` input. It equals `count` when `phase_q[1]` equals `count[0]`. Otherwise it equals `count`+1 if `phase_q[0]`=0, or `count`-1 if `phase_q[0]`=1, modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xing_valid | input | 1 | Zero-crossing event this cycle |
| xing_up | input | 1 | Crossing direction, 1 = count up |
| load_valid | input | 1 | Preload strobe |
| load_value | input | 16 | Absolute value to preload |
| freq_over | input | 1 | Signal frequency above limit |
| vmode | input | 2 | Verification policy |
| abs_valid | input | 1 | Computed absolute value available |
| abs_value | input | 16 | Computed absolute value |
| err_clr | input | 1 | Clears the error flag |
| phase_q | input | 2 | Top two bits of fine-track phase |
| count | output | 16 | Running crossing count |
| sync_count | output | 16 | Phase-aligned count |
| cnt_err | output | 1 | Sticky counter error |

## Verification
Several properties are checked on every cycle:
- the counter steps and holds;
- a preload takes precedence over a crossing;
- the error flag is sticky;
- policy 0, and policy 1 while the frequency is over its limit, never raise the flag;
- an always-compare policy with a mismatch does raise it;
- the aligned output stays within one step of the prior count.

Only the bench scenarios show the rest:
- the exact wrap values;
- which count a strobe is compared against when a crossing arrives in the same cycle;
- verification resuming after the frequency drops;
- set winning over clear;
- each of the four phase-correction cases.

// File: rtl/ptrk_pkg.sv
package ptrk_pkg;
  typedef enum logic [1:0] {
    VPOL_NONE     = 2'b00,
    VPOL_FREQ     = 2'b01,
    VPOL_ALWAYS   = 2'b10,
    VPOL_ALWAYS_X = 2'b11
  } vpol_t;

  function automatic logic policy_allows(input vpol_t pol, input logic over);
    case (pol)
      VPOL_NONE:   policy_allows = 1'b0;
      VPOL_FREQ:   policy_allows = ~over;
      default:     policy_allows = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/ptrk_counter.sv
module ptrk_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_valid,
  input  logic [W-1:0] load_value,
  input  logic         xing_valid,
  input  logic         xing_up,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] STEP = W'(1);

  logic [W-1:0] cnt_next;

  always_comb begin
    cnt_next = cnt;
    if (load_valid)
      cnt_next = load_value;
    else if (xing_valid)
      cnt_next = xing_up ? cnt + STEP : cnt - STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_next;
  end

  // R3
  preload_wins_chk: assert property (@(posedge clk) disable iff (rst)
    load_valid |=> cnt == $past(load_value));
  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_valid && xing_valid && xing_up) |=> cnt == $past(cnt) + STEP);
  // R2
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_valid && xing_valid && !xing_up) |=> cnt == $past(cnt) - STEP);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_valid && !xing_valid) |=> $stable(cnt));
endmodule

// File: rtl/ptrk_verify.sv
module ptrk_verify
  import ptrk_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   vmode,
  input  logic         freq_over,
  input  logic         abs_valid,
  input  logic [W-1:0] abs_value,
  input  logic [W-1:0] cnt,
  input  logic         err_clr,
  output logic         err
);
  logic enabled;
  logic mismatch;

  always_comb begin
    enabled  = abs_valid && policy_allows(vpol_t'(vmode), freq_over);
    mismatch = enabled && (abs_value != cnt);
  end

  always_ff @(posedge clk) begin
    if (rst)           err <= 1'b0;
    else if (mismatch) err <= 1'b1;
    else if (err_clr)  err <= 1'b0;
  end

  // R8
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    (err && !err_clr) |=> err);
  // R4
  off_policy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (abs_valid && vmode == 2'b00 && !err) |=> !err);
  // R5
  over_limit_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (abs_valid && vmode == 2'b01 && freq_over && !err) |=> !err);
  // R6
  always_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (abs_valid && vmode[1] && abs_value != cnt) |=> err);
endmodule

// File: rtl/ptrk_sync.sv
module ptrk_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic [1:0]   phase_q,
  output logic [W-1:0] sync_cnt
);
  localparam logic [W-1:0] STEP = W'(1);

  logic [W-1:0] aligned;

  always_comb begin
    if (phase_q[1] == cnt[0])
      aligned = cnt;
    else if (!phase_q[0])
      aligned = cnt + STEP;
    else
      aligned = cnt - STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) sync_cnt <= '0;
    else     sync_cnt <= aligned;
  end

  // R9
  within_one_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sync_cnt == $past(cnt) || sync_cnt == $past(cnt) + STEP ||
              sync_cnt == $past(cnt) - STEP));
  // R9
  agree_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q[1] == cnt[0]) |=> sync_cnt == $past(cnt));
endmodule

// File: rtl/period_tracker.sv
module period_tracker #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xing_valid,
  input  logic             xing_up,
  input  logic             load_valid,
  input  logic [CNT_W-1:0] load_value,
  input  logic             freq_over,
  input  logic [1:0]       vmode,
  input  logic             abs_valid,
  input  logic [CNT_W-1:0] abs_value,
  input  logic             err_clr,
  input  logic [1:0]       phase_q,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] sync_count,
  output logic             cnt_err
);
  logic [CNT_W-1:0] cnt_q;

  ptrk_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .load_valid(load_valid), .load_value(load_value),
    .xing_valid(xing_valid), .xing_up(xing_up),
    .cnt(cnt_q)
  );

  ptrk_verify #(.W(CNT_W)) u_ver (
    .clk(clk), .rst(rst),
    .vmode(vmode), .freq_over(freq_over),
    .abs_valid(abs_valid), .abs_value(abs_value),
    .cnt(cnt_q), .err_clr(err_clr),
    .err(cnt_err)
  );

  ptrk_sync #(.W(CNT_W)) u_sync (
    .clk(clk), .rst(rst),
    .cnt(cnt_q), .phase_q(phase_q),
    .sync_cnt(sync_count)
  );

  assign count = cnt_q;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (count == '0 && sync_count == '0 && !cnt_err));
endmodule

// File: tb/sim_period_tracker.sv
module sim_period_tracker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xing_valid = 0, xing_up = 0, load_valid = 0;
  logic [15:0] load_value = 0, abs_value = 0;
  logic        freq_over = 0, abs_valid = 0, err_clr = 0;
  logic [1:0]  vmode = 0, phase_q = 0;
  logic [15:0] count, sync_count;
  logic        cnt_err;

  always #5 clk = ~clk;

  period_tracker u0 (
    .clk(clk), .rst(rst), .xing_valid(xing_valid), .xing_up(xing_up),
    .load_valid(load_valid), .load_value(load_value), .freq_over(freq_over),
    .vmode(vmode), .abs_valid(abs_valid), .abs_value(abs_value),
    .err_clr(err_clr), .phase_q(phase_q),
    .count(count), .sync_count(sync_count), .cnt_err(cnt_err)
  );

  typedef struct {
    logic [15:0] cnt;
    logic [15:0] syn;
    logic        err;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0, errors = 0;
  logic [15:0] m_cnt = 0;
  logic        m_err = 0;
  bit          finished = 0;

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected outcome
  task automatic step(input logic xv, input logic xu, input logic lv,
                      input logic [15:0] lval, input logic fo, input logic [1:0] md,
                      input logic av, input logic [15:0] aval, input logic clr,
                      input logic [1:0] ph, input string tag);
    exp_t e;
    logic en;
    @(negedge clk);
    xing_valid = xv; xing_up = xu; load_valid = lv; load_value = lval;
    freq_over = fo; vmode = md; abs_valid = av; abs_value = aval;
    err_clr = clr; phase_q = ph;
    en = av && (md >= 2'd2 || (md == 2'd1 && !fo));
    if (ph[1] == m_cnt[0]) e.syn = m_cnt;
    else if (ph[0] == 1'b0) e.syn = m_cnt + 16'd1;
    else e.syn = m_cnt - 16'd1;
    if (en && aval != m_cnt) m_err = 1'b1;
    else if (clr) m_err = 1'b0;
    if (lv) m_cnt = lval;
    else if (xv) m_cnt = xu ? m_cnt + 16'd1 : m_cnt - 16'd1;
    e.cnt = m_cnt; e.err = m_err; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, {m_cnt[0], 1'b0}, tag);
  endtask

  // monitor: pop and compare after each edge that consumed a pushed item
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "count", count, e.cnt);
        check(e.tag, "sync_count", sync_count, e.syn);
        check(e.tag, "cnt_err", {15'd0, cnt_err}, {15'd0, e.err});
      end
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", "count", count, 16'd0);
    check("R1", "sync_count", sync_count, 16'd0);
    check("R1", "cnt_err", {15'd0, cnt_err}, 16'd0);
    @(negedge clk); rst = 1'b0;

    // R2 counting up and down
    repeat (5) step(1, 1, 0, 0, 0, 0, 0, 0, 0, 2'b00, "R2 up");
    repeat (2) step(1, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, "R2 down");
    idle("R2 hold");
    // R3 preload, then R2 wrap up
    step(0, 0, 1, 16'hFFFF, 0, 0, 0, 0, 0, 2'b00, "R3 preload");
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, 2'b00, "R2 wrap up");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, "R2 wrap down");
    // R3 preload wins over crossing
    step(1, 1, 1, 16'h1234, 0, 0, 0, 0, 0, 2'b00, "R3 priority");
    // R4 policy 0 ignores mismatch
    step(0, 0, 0, 0, 0, 2'd0, 1, 16'h0BAD, 0, 2'b00, "R4 off");
    idle("R4 after");
    // R5 over limit skipped
    step(0, 0, 0, 0, 1, 2'd1, 1, 16'h0BAD, 0, 2'b00, "R5 skip");
    idle("R5 after skip");
    // R5 matching compare under limit
    step(0, 0, 0, 0, 0, 2'd1, 1, 16'h1234, 0, 2'b00, "R5 match");
    // R7 crossing same cycle, compare against pre-edge count
    step(1, 1, 0, 0, 0, 2'd2, 1, 16'h1234, 0, 2'b00, "R7 pre-edge");
    // R5 resumes: mismatch flags
    step(0, 0, 0, 0, 0, 2'd1, 1, 16'h0BAD, 0, 2'b00, "R5 resume");
    // R8 sticky
    idle("R8 sticky");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 2'b00, "R8 clear");
    // R6 mode 3 always compares
    step(0, 0, 0, 0, 1, 2'd3, 1, 16'h0001, 0, 2'b00, "R6 always");
    // R8 set wins over clear
    step(0, 0, 0, 0, 0, 2'd2, 1, 16'h0002, 1, 2'b00, "R8 set over clear");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 2'b00, "R8 clear2");
    // R6 mode 2 match leaves flag low
    step(0, 0, 0, 0, 1, 2'd2, 1, m_cnt, 0, 2'b00, "R6 match");
    // R9 phase corrections, count even (0x1235 -> load even value)
    step(0, 0, 1, 16'h2000, 0, 0, 0, 0, 0, 2'b00, "R9 load");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, "R9 agree q0");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b01, "R9 agree q1");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b10, "R9 plus");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b11, "R9 minus");
    step(0, 0, 1, 16'h0000, 0, 0, 0, 0, 0, 2'b00, "R9 load zero");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b11, "R9 minus wrap");
    step(0, 0, 1, 16'hFFFF, 0, 0, 0, 0, 0, 2'b00, "R9 load max");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, "R9 plus wrap");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b10, "R9 odd agree");
    idle("end");

    repeat (3) @(posedge clk);
    #3;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule